// File: doc/BRIEF.md
# Flash Block Lock-Down Controller

This block keeps one lock-down bit for each block of a small flash array and decides, block by block, whether that block is write-protected. Command writes arrive as a stream of command byte and block index. A two-write sequence sets the lock-down bit of the block named in the second write. That sequence is a setup code followed by a confirm code. A lock-down bit can only be set. It returns to zero only through reset.

The write-protect pin gates the stored bits. While the pin is high the lock-down bits have no effect, but they keep their values. The effective protection of a block is its lock-down bit qualified by the pin, ORed with the block's ordinary lock bit. The ordinary lock bits are supplied from elsewhere. Program and erase sequencers read the protection as a full vector or through a single-block query port.

A bad confirm write raises two error bits in a status byte. These bits stay set until a clear-status command is written. The command stream uses valid/ready. The block asserts ready exactly while the core-supply-good input is high. A writer holds its command until ready is high. A write counts only in a cycle where both valid and ready are high.

Top module: `flash_lockdown_ctrl`

## Requirements
- R1: A write of 60h followed by the next accepted write of 2Fh sets the lock-down bit of the block index carried by the 2Fh write. The bit shows on `lockdown_o` in the cycle after that write is accepted.
- R2: After 60h, a next accepted write of any code other than 2Fh has three effects. It sets status bits 5 and 4 to 1, it leaves every lock-down bit unchanged, and it returns the decoder to idle. This includes 50h.
- R3: The state of `vpp_ok` has no effect on whether the lock-down sequence is accepted or on its result.
- R4: `cmd_ready` equals `supply_ok`. A write presented while `supply_ok` is low is not accepted and does not advance the sequence.
- R5: For each block i, `protect_o[i]` = (`lockdown_o[i]` AND NOT `wp_pin`) OR `lock_bits[i]`, with no clock delay from `wp_pin` or `lock_bits`. A high `wp_pin` does not change `lockdown_o`.
- R6: Reset clears every lock-down bit and the status byte. No command ever turns a set lock-down bit back to 0.
- R7: In idle, an accepted 50h returns status bits 5 and 4 to 0 in the next cycle. Until then, set error bits stay at 1. All other status bits read 0.
- R8: In idle, accepted codes other than 60h and 50h have no effect. This includes a stray 2Fh.
- R9: `query_prot` equals `protect_o[query_block]`, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command write present |
| cmd_ready | output | 1 | Command write can be taken (follows supply_ok) |
| cmd_code | input | 8 | Command byte |
| cmd_block | input | 3 | Target block index |
| supply_ok | input | 1 | Core supply within range |
| vpp_ok | input | 1 | Programming voltage within range (not used for lock-down) |
| wp_pin | input | 1 | Write-protect pin; high masks lock-down bits |
| lock_bits | input | 8 | Ordinary per-block lock bits |
| query_block | input | 3 | Block index to query |
| query_prot | output | 1 | Protection of the queried block |
| lockdown_o | output | 8 | Stored lock-down bits |
| protect_o | output | 8 | Effective per-block protection |
| status_o | output | 8 | Status byte; bit 5 sequence error, bit 4 operation error |

## Verification
Lock-down bits and status bits change one clock after the write that causes them is accepted. The bench drives each write half a cycle before a rising edge and compares one full cycle later, at the following falling edge. Protection and the query output follow `wp_pin`, `lock_bits` and `query_block` with no clock delay. Those checks sample at the falling edge while the inputs are held steady. `cmd_ready` is checked in the same half cycle in which `supply_ok` is changed.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
  localparam logic [7:0] CMD_LD_SETUP   = 8'h60;
  localparam logic [7:0] CMD_LD_CONFIRM = 8'h2F;
  localparam logic [7:0] CMD_CLR_STATUS = 8'h50;

  localparam int SR_SEQ_ERR_BIT = 5;
  localparam int SR_OP_ERR_BIT  = 4;
  localparam int SR_WIDTH       = 8;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_ARMED = 1'b1
  } seq_state_e;
endpackage

// File: rtl/lkd_seq_decoder.sv
module lkd_seq_decoder
  import lkd_pkg::*;
#(
  parameter int BLK_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [7:0]       code,
  input  logic [BLK_W-1:0] block,
  output logic             set_en,
  output logic [BLK_W-1:0] set_idx,
  output logic             err_set,
  output logic             err_clr,
  output logic             armed
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    set_en  = 1'b0;
    err_set = 1'b0;
    err_clr = 1'b0;
    set_idx = block;
    if (accept) begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (code == CMD_LD_SETUP) begin
            state_d = SEQ_ARMED;
          end else if (code == CMD_CLR_STATUS) begin
            err_clr = 1'b1;
          end
        end
        SEQ_ARMED: begin
          state_d = SEQ_IDLE;
          if (code == CMD_LD_CONFIRM) begin
            set_en = 1'b1;
          end else begin
            err_set = 1'b1;
          end
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign armed = (state_q == SEQ_ARMED);

  AST_ARMED_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && accept) |=> !armed); // R2
  AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !set_en); // R8
endmodule

// File: rtl/lkd_store.sv
module lkd_store #(
  parameter int NUM_BLOCKS = 8,
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  set_en,
  input  logic [BLK_W-1:0]      set_idx,
  output logic [NUM_BLOCKS-1:0] ld_q
);
  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_bit
    logic hit;
    assign hit = set_en && (set_idx == BLK_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ld_q[i] <= 1'b0;
      else if (hit) ld_q[i] <= 1'b1;
    end
  end

  AST_LD_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ld_q) & ~ld_q) == '0)); // R6
  AST_LD_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(ld_q & ~$past(ld_q)) <= 1)); // R1
endmodule

// File: rtl/lkd_status.sv
module lkd_status
  import lkd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                err_set,
  input  logic                err_clr,
  output logic [SR_WIDTH-1:0] status
);
  logic seq_err_q, op_err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_err_q <= 1'b0;
      op_err_q  <= 1'b0;
    end else if (err_set) begin
      seq_err_q <= 1'b1;
      op_err_q  <= 1'b1;
    end else if (err_clr) begin
      seq_err_q <= 1'b0;
      op_err_q  <= 1'b0;
    end
  end

  always_comb begin
    status = '0;
    status[SR_SEQ_ERR_BIT] = seq_err_q;
    status[SR_OP_ERR_BIT]  = op_err_q;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[SR_SEQ_ERR_BIT]) |-> $past(err_clr)); // R7
endmodule

// File: rtl/lkd_qualify.sv
module lkd_qualify #(
  parameter int NUM_BLOCKS = 8,
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_BLOCKS-1:0] ld,
  input  logic                  wp,
  input  logic [NUM_BLOCKS-1:0] lock,
  input  logic [BLK_W-1:0]      query_idx,
  output logic [NUM_BLOCKS-1:0] prot,
  output logic                  query_prot
);
  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
    assign prot[i] = (ld[i] && !wp) || lock[i];
  end

  assign query_prot = prot[query_idx];

  AST_WP_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    wp |-> (prot == lock)); // R5
  AST_LOCK_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n)
    ((prot & lock) == lock)); // R5
endmodule

// File: rtl/flash_lockdown_ctrl.sv
module flash_lockdown_ctrl
  import lkd_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [7:0]            cmd_code,
  input  logic [BLK_W-1:0]      cmd_block,
  input  logic                  supply_ok,
  input  logic                  vpp_ok,
  input  logic                  wp_pin,
  input  logic [NUM_BLOCKS-1:0] lock_bits,
  input  logic [BLK_W-1:0]      query_block,
  output logic                  query_prot,
  output logic [NUM_BLOCKS-1:0] lockdown_o,
  output logic [NUM_BLOCKS-1:0] protect_o,
  output logic [SR_WIDTH-1:0]   status_o
);
  logic             accept;
  logic             set_en, err_set, err_clr, armed;
  logic [BLK_W-1:0] set_idx;

  assign cmd_ready = supply_ok;
  assign accept    = cmd_valid && cmd_ready;

  lkd_seq_decoder #(.BLK_W(BLK_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .accept(accept), .code(cmd_code),
    .block(cmd_block), .set_en(set_en), .set_idx(set_idx),
    .err_set(err_set), .err_clr(err_clr), .armed(armed)
  );

  lkd_store #(.NUM_BLOCKS(NUM_BLOCKS)) u_store (
    .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_idx(set_idx),
    .ld_q(lockdown_o)
  );

  lkd_status u_stat (
    .clk(clk), .rst_n(rst_n), .err_set(err_set), .err_clr(err_clr),
    .status(status_o)
  );

  lkd_qualify #(.NUM_BLOCKS(NUM_BLOCKS)) u_qual (
    .clk(clk), .rst_n(rst_n), .ld(lockdown_o), .wp(wp_pin),
    .lock(lock_bits), .query_idx(query_block), .prot(protect_o),
    .query_prot(query_prot)
  );

  AST_CONFIRM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && accept && cmd_code == CMD_LD_CONFIRM) |=> lockdown_o[$past(cmd_block)]); // R1
  AST_NO_VPP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && accept && !vpp_ok && cmd_code == CMD_LD_CONFIRM) |=> lockdown_o[$past(cmd_block)]); // R3
  AST_BAD_CONFIRM_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && accept && cmd_code != CMD_LD_CONFIRM)
      |=> (status_o[SR_SEQ_ERR_BIT] && status_o[SR_OP_ERR_BIT] && lockdown_o == $past(lockdown_o))); // R2
  AST_NO_ACCEPT_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok) |=> (lockdown_o == $past(lockdown_o) && status_o == $past(status_o))); // R4
endmodule

// File: tb/flash_lockdown_ctrl_bench.sv
module flash_lockdown_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_code = 8'h00;
  logic [2:0] cmd_block = 3'd0;
  logic       supply_ok = 1'b1;
  logic       vpp_ok = 1'b1;
  logic       wp_pin = 1'b0;
  logic [7:0] lock_bits = 8'h00;
  logic [2:0] query_block = 3'd0;
  logic       query_prot;
  logic [7:0] lockdown_o, protect_o, status_o;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  flash_lockdown_ctrl u_flash_lockdown_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_block(cmd_block), .supply_ok(supply_ok),
    .vpp_ok(vpp_ok), .wp_pin(wp_pin), .lock_bits(lock_bits),
    .query_block(query_block), .query_prot(query_prot),
    .lockdown_o(lockdown_o), .protect_o(protect_o), .status_o(status_o)
  );

  // {code, block, supply, vpp, wp, lock, exp_lockdown, exp_protect, exp_status}
  localparam int NV = 18;
  localparam logic [45:0] VECS [NV] = '{
    {8'h60, 3'd0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00}, // R1 setup
    {8'h2F, 3'd3, 1'b1, 1'b1, 1'b0, 8'h00, 8'h08, 8'h08, 8'h00}, // R1 confirm block 3
    {8'h60, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h08, 8'h08, 8'h00}, // R3 vpp low
    {8'h2F, 3'd5, 1'b1, 1'b0, 1'b0, 8'h00, 8'h28, 8'h28, 8'h00}, // R3 set under vpp low
    {8'h60, 3'd0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h28, 8'h28, 8'h00}, // R2 setup
    {8'hAA, 3'd1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h28, 8'h28, 8'h30}, // R2 bad confirm
    {8'h2F, 3'd1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h28, 8'h28, 8'h30}, // R8 stray confirm
    {8'h00, 3'd0, 1'b1, 1'b1, 1'b1, 8'h01, 8'h28, 8'h01, 8'h30}, // R5 wp masks, R7 sticky
    {8'h50, 3'd0, 1'b1, 1'b1, 1'b0, 8'h01, 8'h28, 8'h29, 8'h00}, // R7 clear status
    {8'h60, 3'd0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h28, 8'h28, 8'h00}, // R4 unpowered setup
    {8'h2F, 3'd2, 1'b1, 1'b1, 1'b0, 8'h00, 8'h28, 8'h28, 8'h00}, // R4 not armed
    {8'h60, 3'd0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h28, 8'h28, 8'h00}, // R2 setup
    {8'h50, 3'd0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h28, 8'h28, 8'h30}, // R2 clear code as confirm
    {8'h50, 3'd0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h28, 8'h28, 8'h00}, // R7 clear
    {8'h60, 3'd0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h28, 8'h00, 8'h00}, // R5 wp high
    {8'h2F, 3'd7, 1'b1, 1'b1, 1'b1, 8'h00, 8'hA8, 8'h00, 8'h00}, // R5 stored under wp
    {8'h60, 3'd0, 1'b1, 1'b1, 1'b0, 8'h80, 8'hA8, 8'hA8, 8'h00}, // R6 setup
    {8'h2F, 3'd3, 1'b1, 1'b1, 1'b0, 8'h80, 8'hA8, 8'hA8, 8'h00}  // R6 re-set no change
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic write1(input logic [7:0] c, input logic [2:0] b);
    @(negedge clk);
    cmd_code = c; cmd_block = b; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run finished)");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset lockdown", lockdown_o, 8'h00);
    check("R6 reset status", status_o, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 ready with supply", {7'd0, cmd_ready}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      logic [45:0] v;
      v = VECS[i];
      cmd_code  = v[45:38];
      cmd_block = v[37:35];
      supply_ok = v[34];
      vpp_ok    = v[33];
      wp_pin    = v[32];
      lock_bits = v[31:24];
      cmd_valid = 1'b1;
      @(negedge clk);
      check($sformatf("R1/R2/R6 vec %0d lockdown", i), lockdown_o, v[23:16]);
      check($sformatf("R5 vec %0d protect", i), protect_o, v[15:8]);
      check($sformatf("R7 vec %0d status", i), status_o, v[7:0]);
    end
    cmd_valid = 1'b0;
    supply_ok = 1'b1;
    vpp_ok    = 1'b1;

    // R9 query port, lockdown = A8
    wp_pin = 1'b0; lock_bits = 8'h00; query_block = 3'd5;
    @(negedge clk);
    check("R9 query block 5", {7'd0, query_prot}, 8'h01);
    query_block = 3'd1;
    @(negedge clk);
    check("R9 query block 1", {7'd0, query_prot}, 8'h00);
    wp_pin = 1'b1; lock_bits = 8'h02;
    @(negedge clk);
    check("R9 query block 1 locked", {7'd0, query_prot}, 8'h01);
    query_block = 3'd7;
    @(negedge clk);
    check("R9 query block 7 wp", {7'd0, query_prot}, 8'h00);
    check("R5 wp keeps lockdown", lockdown_o, 8'hA8);
    wp_pin = 1'b0; lock_bits = 8'h00;

    // R4 ready follows supply
    @(negedge clk);
    supply_ok = 1'b0;
    #1;
    check("R4 ready low", {7'd0, cmd_ready}, 8'h00);
    supply_ok = 1'b1;

    // R6 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R6 reset clears lockdown", lockdown_o, 8'h00);
    check("R6 reset clears protect", protect_o, 8'h00);
    rst_n = 1'b1;

    // R1 again on block 0 after reset
    write1(8'h60, 3'd4);
    write1(8'h2F, 3'd0);
    check("R1 confirm block 0", lockdown_o, 8'h01);
    check("R7 status idle", status_o, 8'h00);

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule